// File: doc/BRIEF.md
# Free-Running Compare/Capture Timer

This block is a 16-bit timer that sits on an 8-bit register bus. A 16-bit up-counter advances once for each pulse of a chosen count enable. The enable comes from one of three internal prescaler ratios or from the rising edge of an external enable input. Two compare registers raise match flags when the counter equals them, and a match on the first compare register can reload the counter with zero. A capture register takes a copy of the counter on an edge of the capture pin, and the edge polarity can be programmed.

Every 16-bit quantity is moved one byte at a time through a shared byte-wide holding latch, so software always sees and loads a consistent pair of bytes. The status flags are set only by hardware. Software can clear a flag by writing a 0 to its bit, and writing a 1 leaves the flag as it was.

Top module: `frt16_timer`

## Requirements
- R1: After reset, the counter and capture register read 0x0000, both compare registers read 0xFFFF, and the control and status registers read 0x00.
- R2: Control bits [1:0] choose the count enable: 0 counts once every 2 clocks, 1 once every 8, 2 once every 32, and 3 once per rising edge of `ext_clk_en`. The prescaler starts at zero on reset, so the first divide-by-2 count lands on the second clock edge after reset. With no enable pulse, the counter holds its value.
- R3: When a count takes the counter from 0xFFFF to 0x0000, the overflow flag (status bit 4) is set.
- R4: One cycle after the counter equals compare register A, status bit 6 is set. One cycle after it equals compare register B, status bit 5 is set.
- R5: When status bit 0 is 1 and a count occurs while the counter equals compare register A, the counter loads 0x0000 instead of incrementing, and the overflow flag is not set by that count.
- R6: The capture pin passes through a two-stage synchronizer. Control bit 2 selects the edge: 0 for rising, 1 for falling. On the selected edge the counter value is copied into the capture register and status bit 7 is set. The opposite edge does nothing.
- R7: Writing the high byte of the counter or of either compare register only loads the holding latch. Writing the low byte then commits {latch, written byte} in a single cycle. A counter commit takes priority over a count in the same cycle.
- R8: Reading the high byte of the counter or of the capture register also copies its low byte into the holding latch. A low-byte read of those two registers returns the latch, not the live value. Read data is registered and is valid on the cycle after the read strobe.
- R9: Writing 0 to a flag bit (status bits 7..4) clears that flag, and writing 1 has no effect. A hardware set in the same cycle as a clear wins.
- R10: The capture register is read-only: writes to its byte addresses change nothing.
- R11: Byte address map: 0 control, 1 status, 2/3 counter high/low, 4/5 compare A high/low, 6/7 compare B high/low, 8/9 capture high/low. Status bits 3..1 read 0, and unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (takes priority over read) |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_clk_en | input | 1 | External count enable; the counter counts on its rising edge |
| cap_pin | input | 1 | Capture trigger pin |

## Verification
Read data is due one clock after the read strobe. A low-byte commit shows up in the counter at the next edge. A compare flag follows one edge after the counter reaches the compare value. A capture lands on the third edge after the pin changes, because of the two synchronizer flops and the capture register.

The bench drives every input on the falling edge and samples read data at the next falling edge. Before it reads a capture, it waits at least four cycles. To keep counter values deterministic, it freezes the counter by selecting the external enable and holding that input low. The prescaler ratios are measured as the counter difference between two reads whose high-byte strobes are exactly 64 cycles apart, which is a whole number of periods for every ratio.

// File: rtl/frt16_pkg.sv
package frt16_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  localparam int ADR_CTRL   = 0;
  localparam int ADR_STAT   = 1;
  localparam int ADR_CNT_H  = 2;
  localparam int ADR_CNT_L  = 3;
  localparam int ADR_CMPA_H = 4;
  localparam int ADR_CMPA_L = 5;
  localparam int ADR_CMPB_H = 6;
  localparam int ADR_CMPB_L = 7;
  localparam int ADR_CAP_H  = 8;
  localparam int ADR_CAP_L  = 9;

  typedef enum logic [1:0] {
    CK_DIV_A = 2'd0,
    CK_DIV_B = 2'd1,
    CK_DIV_C = 2'd2,
    CK_EXT   = 2'd3
  } clk_sel_e;

  // flag vector index (status bit = index + 4)
  localparam int FL_OVF = 0;
  localparam int FL_CMB = 1;
  localparam int FL_CMA = 2;
  localparam int FL_CAP = 3;
  localparam int N_FLAGS = 4;
endpackage

// File: rtl/frt16_prescale.sv
module frt16_prescale #(
  parameter int PRE_W = 5,
  parameter int LOG_A = 1,
  parameter int LOG_B = 3,
  parameter int LOG_C = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       ext_in,
  output logic       tick
);
  import frt16_pkg::*;

  localparam int N_DIV = 3;
  localparam int LOGS [N_DIV] = '{LOG_A, LOG_B, LOG_C};

  logic [PRE_W-1:0] pre_q;
  logic             ext_q;
  logic [N_DIV-1:0] div_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      ext_q <= 1'b0;
    end else begin
      pre_q <= pre_q + 1'b1;
      ext_q <= ext_in;
    end
  end

  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << LOGS[g]) - 1);
    assign div_tick[g] = &(pre_q | ~MASK);
  end

  always_comb begin
    unique case (clk_sel_e'(sel))
      CK_DIV_A: tick = div_tick[0];
      CK_DIV_B: tick = div_tick[1];
      CK_DIV_C: tick = div_tick[2];
      default:  tick = ext_in & ~ext_q;
    endcase
  end
endmodule

// File: rtl/frt16_capsync.sv
module frt16_capsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic falling,
  output logic edge_hit
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], pin};
  end

  logic lvl, prv;
  assign lvl = sh_q[STAGES-1];
  assign prv = sh_q[STAGES];
  assign edge_hit = falling ? (prv & ~lvl) : (lvl & ~prv);
endmodule

// File: rtl/frt16_cmpreg.sv
module frt16_cmpreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] val,
  output logic         match
);
  always_ff @(posedge clk) begin
    if (rst)       val <= '1;
    else if (load) val <= load_val;
  end
  assign match = (val == cnt);
endmodule

// File: rtl/frt16_timer.sv
module frt16_timer #(
  parameter int ADDR_W  = 4,
  parameter int PRE_W   = 5,
  parameter int LOG_A   = 1,
  parameter int LOG_B   = 3,
  parameter int LOG_C   = 5,
  parameter int SYNC_N  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        ext_clk_en,
  input  logic        cap_pin
);
  import frt16_pkg::*;

  localparam int N_CMP = 2;

  // bus decode
  logic wr_en, rd_en;
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & bus_rd & ~bus_wr;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int n);
    return a == ADDR_W'(n);
  endfunction

  // state
  logic [2:0]         ctrl_q;
  logic               clr_en;
  logic [N_FLAGS-1:0] flags_q;
  logic [BYTE_W-1:0]  temp_q;
  logic [WORD_W-1:0]  cnt_q;
  logic [WORD_W-1:0]  cap_q;
  logic [WORD_W-1:0]  cmp_val [N_CMP];
  logic [N_CMP-1:0]   cmp_hit;
  logic [N_CMP-1:0]   cmp_load;
  logic               tick;
  logic               cap_edge;

  logic stat_wr, cnt_commit, hi_wr, clr_hit;
  assign stat_wr    = wr_en & at(bus_addr, ADR_STAT);
  assign cnt_commit = wr_en & at(bus_addr, ADR_CNT_L);
  assign hi_wr      = wr_en & (at(bus_addr, ADR_CNT_H) | at(bus_addr, ADR_CMPA_H) |
                               at(bus_addr, ADR_CMPB_H));
  assign cmp_load[0] = wr_en & at(bus_addr, ADR_CMPA_L);
  assign cmp_load[1] = wr_en & at(bus_addr, ADR_CMPB_L);
  assign clr_hit    = clr_en & cmp_hit[0];

  frt16_prescale #(.PRE_W(PRE_W), .LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C)) u_pre (
    .clk(clk), .rst(rst), .sel(ctrl_q[1:0]), .ext_in(ext_clk_en), .tick(tick)
  );

  frt16_capsync #(.STAGES(SYNC_N)) u_cap (
    .clk(clk), .rst(rst), .pin(cap_pin), .falling(ctrl_q[2]), .edge_hit(cap_edge)
  );

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    frt16_cmpreg #(.W(WORD_W)) u_cmp (
      .clk(clk), .rst(rst), .load(cmp_load[g]), .load_val({temp_q, bus_wdata}),
      .cnt(cnt_q), .val(cmp_val[g]), .match(cmp_hit[g])
    );
  end

  // counter
  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (cnt_commit) cnt_q <= {temp_q, bus_wdata};
    else if (tick)       cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
  end

  // flags: hardware set wins over software clear
  logic [N_FLAGS-1:0] hw_set, sw_clr;
  always_comb begin
    hw_set          = '0;
    hw_set[FL_OVF]  = tick & ~cnt_commit & ~clr_hit & (&cnt_q);
    hw_set[FL_CMA]  = cmp_hit[0];
    hw_set[FL_CMB]  = cmp_hit[1];
    hw_set[FL_CAP]  = cap_edge;
    sw_clr          = stat_wr ? ~bus_wdata[7:4] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      clr_en  <= 1'b0;
      ctrl_q  <= '0;
      cap_q   <= '0;
    end else begin
      flags_q <= hw_set | (flags_q & ~sw_clr);
      if (stat_wr) clr_en <= bus_wdata[0];
      if (wr_en && at(bus_addr, ADR_CTRL)) ctrl_q <= bus_wdata[2:0];
      if (cap_edge) cap_q <= cnt_q;
    end
  end

  // holding latch and registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      temp_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (hi_wr) temp_q <= bus_wdata;
      else if (rd_en && at(bus_addr, ADR_CNT_H)) temp_q <= cnt_q[BYTE_W-1:0];
      else if (rd_en && at(bus_addr, ADR_CAP_H)) temp_q <= cap_q[BYTE_W-1:0];
      if (rd_en) begin
        unique case (int'(bus_addr))
          ADR_CTRL:   bus_rdata <= {5'd0, ctrl_q};
          ADR_STAT:   bus_rdata <= {flags_q, 3'd0, clr_en};
          ADR_CNT_H:  bus_rdata <= cnt_q[WORD_W-1:BYTE_W];
          ADR_CNT_L:  bus_rdata <= temp_q;
          ADR_CMPA_H: bus_rdata <= cmp_val[0][WORD_W-1:BYTE_W];
          ADR_CMPA_L: bus_rdata <= cmp_val[0][BYTE_W-1:0];
          ADR_CMPB_H: bus_rdata <= cmp_val[1][WORD_W-1:BYTE_W];
          ADR_CMPB_L: bus_rdata <= cmp_val[1][BYTE_W-1:0];
          ADR_CAP_H:  bus_rdata <= cap_q[WORD_W-1:BYTE_W];
          ADR_CAP_L:  bus_rdata <= temp_q;
          default:    bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/frt16_timer_chk.sv
module frt16_timer_chk (
  input logic        clk,
  input logic        rst,
  input logic        tick,
  input logic        cnt_commit,
  input logic        clr_en,
  input logic        cap_edge,
  input logic [3:0]  flags_q,
  input logic [7:0]  temp_q,
  input logic [7:0]  bus_wdata,
  input logic [15:0] cnt_q,
  input logic [15:0] cap_q,
  input logic [15:0] cmpa_v,
  input logic [15:0] cmpb_v
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_commit) |=> $stable(cnt_q));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_commit && !(clr_en && cnt_q == cmpa_v)) |=> cnt_q == $past(cnt_q) + 16'd1);
  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_commit && cnt_q == 16'hFFFF && !(clr_en && cnt_q == cmpa_v)) |=> flags_q[0]);
  // R4
  cmpa_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == cmpa_v) |=> flags_q[2]);
  // R4
  cmpb_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == cmpb_v) |=> flags_q[1]);
  // R5
  clr_on_a_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_commit && clr_en && cnt_q == cmpa_v) |=> cnt_q == 16'h0000);
  // R6
  cap_load_chk: assert property (@(posedge clk) disable iff (rst)
    cap_edge |=> (cap_q == $past(cnt_q) && flags_q[3]));
  // R7
  cnt_commit_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_commit |=> cnt_q == {$past(temp_q), $past(bus_wdata)});
  // R9
  ovf_hw_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[0]) |-> $past(tick));
  // R10
  cap_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_edge |=> $stable(cap_q));
endmodule

bind frt16_timer frt16_timer_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cnt_commit(cnt_commit), .clr_en(clr_en),
  .cap_edge(cap_edge), .flags_q(flags_q), .temp_q(temp_q), .bus_wdata(bus_wdata),
  .cnt_q(cnt_q), .cap_q(cap_q), .cmpa_v(cmp_val[0]), .cmpb_v(cmp_val[1])
);

// File: tb/frt16_timer_tb.sv
`timescale 1ns/1ps
module frt16_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_clk_en = 1'b0;
  logic       cap_pin = 1'b0;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  frt16_timer u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk_en(ext_clk_en), .cap_pin(cap_pin)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // every bus task starts and ends on a falling edge
  task automatic wr8(input int a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd8(input int a, output logic [7:0] d);
    bus_sel = 1; bus_rd = 1; bus_addr = 4'(a);
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic wr16(input int hi, input logic [15:0] v);
    wr8(hi, v[15:8]);
    wr8(hi + 1, v[7:0]);
  endtask

  task automatic rd16(input int hi, output logic [15:0] v);
    logic [7:0] h, l;
    rd8(hi, h);
    rd8(hi + 1, l);
    v = {h, l};
  endtask

  task automatic ext_pulse();
    ext_clk_en = 1; @(negedge clk);
    ext_clk_en = 0; @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v; logic [7:0] b;
    rd16(2, v);  check("R1 counter", v, 16'h0000);
    rd8(0, b);   check("R1 control", {8'h0, b}, 16'h0000);
    rd8(1, b);   check("R1 status", {8'h0, b}, 16'h0000);
    rd16(4, v);  check("R1 compare A", v, 16'hFFFF);
    rd16(6, v);  check("R1 compare B", v, 16'hFFFF);
    rd16(8, v);  check("R1 capture", v, 16'h0000);
    rd8(12, b);  check("R11 unmapped", {8'h0, b}, 16'h0000);
  endtask

  task automatic measure(input logic [7:0] sel, input logic [15:0] exp, input string req);
    logic [15:0] a, b;
    wr8(0, sel);
    rd16(2, a);
    repeat (62) @(negedge clk);
    rd16(2, b);
    check(req, b - a, exp);
  endtask

  task automatic t_rates();
    logic [15:0] a, b;
    measure(8'h00, 16'd32, "R2 div2");
    measure(8'h01, 16'd8,  "R2 div8");
    measure(8'h02, 16'd2,  "R2 div32");
    wr8(0, 8'h03);
    rd16(2, a);
    repeat (5) ext_pulse();
    rd16(2, b);
    check("R2 ext pulses", b - a, 16'd5);
    ext_clk_en = 1; repeat (10) @(negedge clk); ext_clk_en = 0; @(negedge clk);
    rd16(2, a);
    check("R2 ext held high", a - b, 16'd1);
  endtask

  task automatic t_access();
    logic [15:0] v; logic [7:0] b;
    wr16(2, 16'h1234);
    rd16(2, v);  check("R7 counter write", v, 16'h1234);
    wr8(2, 8'hAB);
    repeat (3) @(negedge clk);
    rd16(2, v);  check("R7 high byte alone", v, 16'h1234);
    wr8(2, 8'hAB); wr8(3, 8'hCD);
    rd16(2, v);  check("R7 pair commit", v, 16'hABCD);
    wr16(6, 16'h0ABC);
    rd16(6, v);  check("R7 compare B write", v, 16'h0ABC);
    wr16(2, 16'h12FF);
    rd8(2, b);
    ext_pulse();
    rd8(3, b);   check("R8 latched low byte", {8'h0, b}, 16'h00FF);
    rd16(2, v);  check("R8 live after tick", v, 16'h1300);
  endtask

  task automatic t_compare();
    logic [7:0] b;
    wr8(1, 8'h00);
    wr16(4, 16'h0010); wr16(6, 16'h0012); wr16(2, 16'h000F);
    wr8(1, 8'h00);
    rd8(1, b);   check("R4 no match yet", {8'h0, b}, 16'h0000);
    ext_pulse();
    rd8(1, b);   check("R4 match A", {8'h0, b}, 16'h0040);
    ext_pulse(); ext_pulse();
    rd8(1, b);   check("R4 match B", {8'h0, b}, 16'h0060);
    wr8(1, 8'h00);
    rd8(1, b);   check("R9 set wins over clear", {8'h0, b}, 16'h0020);
  endtask

  task automatic t_clear_a();
    logic [15:0] v; logic [7:0] b;
    wr16(4, 16'h0003); wr16(2, 16'h0002);
    wr8(1, 8'h01);
    ext_pulse();
    rd16(2, v);  check("R5 reaches A", v, 16'h0003);
    ext_pulse();
    rd16(2, v);  check("R5 cleared on A", v, 16'h0000);
    rd8(1, b);   check("R5 flags no ovf", {8'h0, b}, 16'h0041);
  endtask

  task automatic t_overflow();
    logic [15:0] v; logic [7:0] b;
    wr16(2, 16'hFFFF);
    wr8(1, 8'h00);
    ext_pulse();
    rd16(2, v);  check("R3 wrap", v, 16'h0000);
    rd8(1, b);   check("R3 overflow flag", {8'h0, b}, 16'h0010);
    wr8(1, 8'hE0);
    rd8(1, b);   check("R9 clear by zero", {8'h0, b}, 16'h0000);
    wr8(1, 8'hF0);
    rd8(1, b);   check("R9 write one no effect", {8'h0, b}, 16'h0000);
  endtask

  task automatic t_capture();
    logic [15:0] v; logic [7:0] b;
    wr8(0, 8'h03);
    wr16(2, 16'h5A5A);
    cap_pin = 1; repeat (4) @(negedge clk);
    rd16(8, v);  check("R6 rising capture", v, 16'h5A5A);
    rd8(1, b);   check("R6 capture flag", {8'h0, b}, 16'h0080);
    wr8(1, 8'h00);
    wr8(0, 8'h07);
    wr16(2, 16'h2222);
    cap_pin = 0; repeat (4) @(negedge clk);
    rd16(8, v);  check("R6 falling capture", v, 16'h2222);
    wr8(1, 8'h00);
    wr16(2, 16'h3333);
    cap_pin = 1; repeat (4) @(negedge clk);
    rd16(8, v);  check("R6 opposite edge ignored", v, 16'h2222);
    rd8(1, b);   check("R6 no flag on opposite edge", {8'h0, b}, 16'h0000);
    wr8(8, 8'h99); wr8(9, 8'h88);
    rd16(8, v);  check("R10 capture read-only", v, 16'h2222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_rates();
    t_access();
    t_compare();
    t_clear_a();
    t_overflow();
    t_capture();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule